// File: doc/BRIEF.md
# Root Port Status and Control Register

This block holds the 32-bit status and control word for one downstream port of a USB host controller. Software reads the word and writes it through a one-cycle write port. The port hardware reports connection, over-current, link-state, speed, configuration-error and cold-attach events on handshake inputs. The register keeps the live status fields current and latches each event into a sticky change flag. Software clears a change flag by writing 1 to its bit. A single output is high while any change flag is set, so the block can feed an interrupt or event path.

Software starts a port reset or a warm reset by writing the word. The register then shows the reset as in progress and drives a request output. It waits for a completion pulse, then records the completion in the change flags and captures the negotiated speed. Link-state writes from software take effect only when the strobe bit in the same write is 1. The PHY and link training are outside the block and are modelled by the handshake inputs.

Top module: `rport_sc`

## Requirements
- R1: After reset, rd_data reads 0x000000A0 (link state RxDetect, code 5, in bits 8:5; every other bit 0) and chg_any is 0.
- R2: Bit 0 follows hw_connect and bit 3 follows hw_oc, one clock later. Any change of hw_connect sets bit 17, and any change of hw_oc sets bit 20.
- R3: A write sets bits 8:5 to wr_data[8:5] only when wr_data[16] is 1. Without the strobe the field is unchanged. A hw_ls_valid report in the same cycle wins. Bit 16 always reads 0.
- R4: Writing 1 to bit 4 sets bit 4 and rst_req. A later rst_done pulse clears bit 4 and sets bit 21. If the port is connected and free of over-current, it also sets bit 1 (enabled) and bit 18. rst_done has no effect while no reset is in progress.
- R5: Writing 1 to bit 31 starts a warm reset: bit 4 and warm_active go to 1, and bit 31 reads 0. The rst_done pulse that completes it sets bits 19 and 21 and clears the cold-attach bit 24.
- R6: Writing 1 to a change flag (bits 23:17) clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R7: chg_any is 1 exactly when at least one of bits 23:17 is 1.
- R8: A hw_ls_valid report sets bit 22 when it moves the field from 3 to 15, 15 to 0, 8 to 0, 3 to 0, 2 to 0 or 0 to 4, or from any other code to 6. Every other report leaves bit 22 unchanged.
- R9: Bits 13:10 read 0 until the first port reset completes. Each reset completion then loads them from hw_speed.
- R10: Writing 1 to bit 1 disables an enabled port without setting bit 18. A disconnect or an over-current clears bit 1 and sets bit 18.
- R11: Bit 9 (power), bits 15:14 (indicator) and bits 27:25 (wake enables) are read/write. Bits 2, 16 and 31:28 always read 0.
- R12: A pulse on hw_cfg_err sets bit 23, and a pulse on hw_cold_attach sets bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Current register value |
| hw_connect | input | 1 | Live device-present level |
| hw_oc | input | 1 | Live over-current level |
| hw_ls_valid | input | 1 | Link-state report qualifier |
| hw_ls | input | 4 | Reported link-state code |
| hw_speed | input | 4 | Negotiated speed, sampled at reset completion |
| hw_cfg_err | input | 1 | Link-partner configuration failure pulse |
| hw_cold_attach | input | 1 | Attach-during-sleep pulse |
| rst_done | input | 1 | Reset completion pulse |
| rst_req | output | 1 | Reset signalling request to the port |
| warm_active | output | 1 | The running reset is a warm reset |
| chg_any | output | 1 | OR of all change flags |

## Verification
The link-change flag is driven with a table of from/to code pairs. The table holds each listed transition together with near misses: U0 to U0, U0 to U1, U1 to U0, Resume to Recovery, and Inactive to Inactive. A wrong or missing entry in the transition decode shows up as a mismatch. Resets are exercised in both forms, with different hw_speed values, to show that the speed field is captured at each completion and is zero before the first. Directed cases separate the enable change caused by software from the one caused by hardware. They also check a clear and a set of a change flag in the same cycle, and a completion pulse that arrives while no reset is pending.

// File: rtl/rport_pkg.sv
package rport_pkg;
  parameter int unsigned REG_W = 32;
  parameter int unsigned LS_W  = 4;
  parameter int unsigned SPD_W = 4;
  parameter int unsigned NCHG  = 7;

  // field positions (software-visible layout)
  localparam int B_CONN  = 0;
  localparam int B_EN    = 1;
  localparam int B_OC    = 3;
  localparam int B_PR    = 4;
  localparam int B_LS    = 5;
  localparam int B_PWR   = 9;
  localparam int B_SPD   = 10;
  localparam int B_IND   = 14;
  localparam int B_STRB  = 16;
  localparam int B_CHG   = 17;
  localparam int B_CAS   = 24;
  localparam int B_WAKE  = 25;
  localparam int B_WPR   = 31;

  // change flag index within the bank
  localparam int F_CSC = 0;
  localparam int F_PEC = 1;
  localparam int F_WRC = 2;
  localparam int F_OCC = 3;
  localparam int F_PRC = 4;
  localparam int F_PLC = 5;
  localparam int F_CEC = 6;

  localparam logic [LS_W-1:0] LS_U0   = 4'd0;
  localparam logic [LS_W-1:0] LS_U2   = 4'd2;
  localparam logic [LS_W-1:0] LS_U3   = 4'd3;
  localparam logic [LS_W-1:0] LS_DIS  = 4'd4;
  localparam logic [LS_W-1:0] LS_RXD  = 4'd5;
  localparam logic [LS_W-1:0] LS_INA  = 4'd6;
  localparam logic [LS_W-1:0] LS_REC  = 4'd8;
  localparam logic [LS_W-1:0] LS_RSM  = 4'd15;

  function automatic logic plc_hit(input logic [LS_W-1:0] o, input logic [LS_W-1:0] n);
    return ((o == LS_U3)  && (n == LS_RSM)) ||
           ((o == LS_RSM) && (n == LS_U0))  ||
           ((o == LS_REC) && (n == LS_U0))  ||
           ((o == LS_U3)  && (n == LS_U0))  ||
           ((o == LS_U2)  && (n == LS_U0))  ||
           ((o == LS_U0)  && (n == LS_DIS)) ||
           ((o != LS_INA) && (n == LS_INA));
  endfunction
endpackage

// File: rtl/rport_rst_sync.sv
module rport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/rport_w1c_bank.sv
module rport_w1c_bank #(
  parameter int unsigned NF = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o
);
  logic [NF-1:0] q, d, en;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_comb begin
      en[g] = set_i[g] | clr_i[g];
      d[g]  = set_i[g] | (q[g] & ~clr_i[g]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= 1'b0;
      else if (en[g]) q[g] <= d[g];
    end
  end

  assign flag_o = q;
endmodule

// File: rtl/rport_link_track.sv
module rport_link_track
  import rport_pkg::*;
#(
  parameter logic [LS_W-1:0] LS_INIT = LS_RXD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_vld,
  input  logic [LS_W-1:0] hw_code,
  input  logic            sw_wr,
  input  logic [LS_W-1:0] sw_code,
  output logic [LS_W-1:0] ls_o,
  output logic            plc_set
);
  logic [LS_W-1:0] ls_q, ls_d;
  logic            ls_en;

  always_comb begin
    ls_en   = hw_vld | sw_wr;
    ls_d    = hw_vld ? hw_code : sw_code;
    plc_set = hw_vld && plc_hit(ls_q, hw_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ls_q <= LS_INIT;
    else if (ls_en) ls_q <= ls_d;
  end

  assign ls_o = ls_q;
endmodule

// File: rtl/rport_reset_seq.sv
module rport_reset_seq
  import rport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_pr,
  input  logic             sw_wpr,
  input  logic             done_i,
  input  logic [SPD_W-1:0] speed_i,
  input  logic             cold_att_i,
  output logic             pr_o,
  output logic             warm_o,
  output logic [SPD_W-1:0] speed_o,
  output logic             cas_o,
  output logic             done_ev,
  output logic             wrc_set
);
  logic             pr_q, pr_d, warm_q, warm_d, cas_q, cas_d;
  logic [SPD_W-1:0] spd_q;

  always_comb begin
    done_ev = pr_q & done_i;
    wrc_set = done_ev & warm_q;
    pr_d    = done_ev ? 1'b0 : ((sw_pr | sw_wpr) ? 1'b1 : pr_q);
    warm_d  = done_ev ? 1'b0 : (sw_wpr ? 1'b1 : warm_q);
    cas_d   = cold_att_i ? 1'b1 : (wrc_set ? 1'b0 : cas_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q   <= 1'b0;
      warm_q <= 1'b0;
      cas_q  <= 1'b0;
      spd_q  <= '0;
    end else begin
      pr_q   <= pr_d;
      warm_q <= warm_d;
      cas_q  <= cas_d;
      if (done_ev) spd_q <= speed_i;
    end
  end

  assign pr_o    = pr_q;
  assign warm_o  = warm_q;
  assign cas_o   = cas_q;
  assign speed_o = spd_q;
endmodule

// File: rtl/rport_sc.sv
module rport_sc
  import rport_pkg::*;
#(
  parameter logic [LS_W-1:0] LS_INIT = LS_RXD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             hw_connect,
  input  logic             hw_oc,
  input  logic             hw_ls_valid,
  input  logic [LS_W-1:0]  hw_ls,
  input  logic [SPD_W-1:0] hw_speed,
  input  logic             hw_cfg_err,
  input  logic             hw_cold_attach,
  input  logic             rst_done,
  output logic             rst_req,
  output logic             warm_active,
  output logic             chg_any
);
  logic             rst_n_s;
  logic             conn_q, oc_q, en_q, en_d, pwr_q;
  logic [1:0]       ind_q;
  logic [2:0]       wake_q;
  logic             en_hw_on, en_hw_off, en_sw_off;
  logic [NCHG-1:0]  chg_set, chg_clr, chg_q;
  logic [LS_W-1:0]  ls_cur;
  logic [SPD_W-1:0] spd_cur;
  logic             plc_set, pr_cur, warm_cur, cas_cur, done_ev, wrc_set;

  rport_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  rport_link_track #(.LS_INIT(LS_INIT)) u_link (
    .clk(clk), .rst_n(rst_n_s),
    .hw_vld(hw_ls_valid), .hw_code(hw_ls),
    .sw_wr(wr_en & wr_data[B_STRB]), .sw_code(wr_data[B_LS +: LS_W]),
    .ls_o(ls_cur), .plc_set(plc_set)
  );

  rport_reset_seq u_rseq (
    .clk(clk), .rst_n(rst_n_s),
    .sw_pr(wr_en & wr_data[B_PR]), .sw_wpr(wr_en & wr_data[B_WPR]),
    .done_i(rst_done), .speed_i(hw_speed), .cold_att_i(hw_cold_attach),
    .pr_o(pr_cur), .warm_o(warm_cur), .speed_o(spd_cur), .cas_o(cas_cur),
    .done_ev(done_ev), .wrc_set(wrc_set)
  );

  // enable bit: hardware events take priority over software disable
  always_comb begin
    en_hw_on  = done_ev & hw_connect & ~hw_oc;
    en_hw_off = en_q & (~hw_connect | hw_oc);
    en_sw_off = wr_en & wr_data[B_EN] & en_q;
    if (en_hw_on)       en_d = 1'b1;
    else if (en_hw_off) en_d = 1'b0;
    else if (en_sw_off) en_d = 1'b0;
    else                en_d = en_q;
  end

  always_comb begin
    chg_set        = '0;
    chg_set[F_CSC] = hw_connect ^ conn_q;
    chg_set[F_PEC] = (en_hw_on & ~en_q) | en_hw_off;
    chg_set[F_WRC] = wrc_set;
    chg_set[F_OCC] = hw_oc ^ oc_q;
    chg_set[F_PRC] = done_ev;
    chg_set[F_PLC] = plc_set;
    chg_set[F_CEC] = hw_cfg_err;
    chg_clr        = {NCHG{wr_en}} & wr_data[B_CHG +: NCHG];
  end

  rport_w1c_bank #(.NF(NCHG)) u_chg (
    .clk(clk), .rst_n(rst_n_s), .set_i(chg_set), .clr_i(chg_clr), .flag_o(chg_q)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
      en_q   <= 1'b0;
      pwr_q  <= 1'b0;
      ind_q  <= '0;
      wake_q <= '0;
    end else begin
      conn_q <= hw_connect;
      oc_q   <= hw_oc;
      en_q   <= en_d;
      if (wr_en) begin
        pwr_q  <= wr_data[B_PWR];
        ind_q  <= wr_data[B_IND +: 2];
        wake_q <= wr_data[B_WAKE +: 3];
      end
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[B_CONN]          = conn_q;
    rd_data[B_EN]            = en_q;
    rd_data[B_OC]            = oc_q;
    rd_data[B_PR]            = pr_cur;
    rd_data[B_LS +: LS_W]    = ls_cur;
    rd_data[B_PWR]           = pwr_q;
    rd_data[B_SPD +: SPD_W]  = spd_cur;
    rd_data[B_IND +: 2]      = ind_q;
    rd_data[B_CHG +: NCHG]   = chg_q;
    rd_data[B_CAS]           = cas_cur;
    rd_data[B_WAKE +: 3]     = wake_q;
  end

  assign rst_req     = pr_cur;
  assign warm_active = warm_cur;
  assign chg_any     = |chg_q;
endmodule

// File: rtl/rport_sc_chk.sv
module rport_sc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        hw_oc,
  input logic        hw_ls_valid,
  input logic        hw_cold_attach,
  input logic        rst_done,
  input logic        warm_active,
  input logic        chg_any
);
  // R7
  p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_any == (|rd_data[23:17]));
  // R4
  p_rc_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[4]) |-> rd_data[21]);
  // R3
  p_ls_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[16] && !hw_ls_valid) |=> $stable(rd_data[8:5]));
  // R5
  p_warm_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_active && rst_done && !hw_cold_attach) |=> (rd_data[19] && !rd_data[24] && !warm_active));
  // R6
  p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[20] && (hw_oc == rd_data[3])) |=> !rd_data[20]);
endmodule

bind rport_sc rport_sc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .hw_oc(hw_oc), .hw_ls_valid(hw_ls_valid), .hw_cold_attach(hw_cold_attach),
  .rst_done(rst_done), .warm_active(warm_active), .chg_any(chg_any)
);

// File: tb/sim_rport_sc.sv
module sim_rport_sc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        hw_connect = 1'b0, hw_oc = 1'b0, hw_ls_valid = 1'b0;
  logic [3:0]  hw_ls = '0, hw_speed = '0;
  logic        hw_cfg_err = 1'b0, hw_cold_attach = 1'b0, rst_done = 1'b0;
  logic        rst_req, warm_active, chg_any;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rport_sc u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hw_connect(hw_connect), .hw_oc(hw_oc), .hw_ls_valid(hw_ls_valid), .hw_ls(hw_ls),
    .hw_speed(hw_speed), .hw_cfg_err(hw_cfg_err), .hw_cold_attach(hw_cold_attach),
    .rst_done(rst_done), .rst_req(rst_req), .warm_active(warm_active), .chg_any(chg_any)
  );

  // {from, to, link-change expected}
  localparam logic [8:0] VEC [14] = '{
    {4'd3, 4'd15, 1'b1}, {4'd15, 4'd0, 1'b1}, {4'd8, 4'd0, 1'b1}, {4'd3, 4'd0, 1'b1},
    {4'd2, 4'd0, 1'b1},  {4'd0, 4'd4, 1'b1},  {4'd0, 4'd6, 1'b1}, {4'd7, 4'd6, 1'b1},
    {4'd0, 4'd0, 1'b0},  {4'd0, 4'd1, 1'b0},  {4'd1, 4'd0, 1'b0}, {4'd15, 4'd8, 1'b0},
    {4'd6, 4'd6, 1'b0},  {4'd5, 4'd7, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ls_report(input logic [3:0] c);
    @(negedge clk); hw_ls_valid = 1'b1; hw_ls = c;
    @(negedge clk); hw_ls_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); rst_done = 1'b1;
    @(negedge clk); rst_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 word", rd_data, 32'h0000_00A0);
    check("R1 chg_any", {31'd0, chg_any}, 32'd0);

    // R3 strobe gating
    wr(32'h0000_0060);
    check("R3 no strobe", {28'd0, rd_data[8:5]}, 32'd5);
    wr(32'h0001_0060);
    check("R3 strobe", {28'd0, rd_data[8:5]}, 32'd3);
    check("R3 bit16 zero", {31'd0, rd_data[16]}, 32'd0);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h0001_00E0; hw_ls_valid = 1'b1; hw_ls = 4'd1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0; hw_ls_valid = 1'b0;
    check("R3 hw wins", {28'd0, rd_data[8:5]}, 32'd1);

    // R2 connect, R7 summary
    @(negedge clk); hw_connect = 1'b1;
    @(negedge clk);
    check("R2 conn", {31'd0, rd_data[0]}, 32'd1);
    check("R2 csc", {31'd0, rd_data[17]}, 32'd1);
    check("R7 any set", {31'd0, chg_any}, 32'd1);
    wr(32'h0000_0000);
    check("R6 write0 keeps", {31'd0, rd_data[17]}, 32'd1);
    wr(32'h0002_0000);
    check("R6 w1c", {31'd0, rd_data[17]}, 32'd0);
    check("R7 any clear", {31'd0, chg_any}, 32'd0);
    // R6 set wins over clear
    @(negedge clk); hw_connect = 1'b0; wr_en = 1'b1; wr_data = 32'h0002_0000;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R6 set wins", {31'd0, rd_data[17]}, 32'd1);
    @(negedge clk); hw_connect = 1'b1;
    @(negedge clk);
    wr(32'h00FE_0000);

    // R2 over-current
    @(negedge clk); hw_oc = 1'b1;
    @(negedge clk);
    check("R2 oc", {31'd0, rd_data[3]}, 32'd1);
    check("R2 occ", {31'd0, rd_data[20]}, 32'd1);
    @(negedge clk); hw_oc = 1'b0;
    @(negedge clk);
    check("R2 oc low", {31'd0, rd_data[3]}, 32'd0);
    check("R2 occ sticky", {31'd0, rd_data[20]}, 32'd1);
    wr(32'h00FE_0000);

    // R4 idle done ignored, R9 speed before reset
    hw_speed = 4'd3;
    pulse_done();
    check("R4 idle done", {31'd0, rd_data[21]}, 32'd0);
    check("R9 speed zero", {28'd0, rd_data[13:10]}, 32'd0);
    // R4 port reset
    wr(32'h0000_0010);
    check("R4 pr set", {31'd0, rd_data[4]}, 32'd1);
    check("R4 rst_req", {31'd0, rst_req}, 32'd1);
    pulse_done();
    check("R4 pr clear", {31'd0, rd_data[4]}, 32'd0);
    check("R4 prc", {31'd0, rd_data[21]}, 32'd1);
    check("R4 enabled", {31'd0, rd_data[1]}, 32'd1);
    check("R4 pec", {31'd0, rd_data[18]}, 32'd1);
    check("R9 speed", {28'd0, rd_data[13:10]}, 32'd3);
    wr(32'h00FE_0000);

    // R10 software disable
    wr(32'h0000_0002);
    check("R10 sw disable", {31'd0, rd_data[1]}, 32'd0);
    check("R10 no pec", {31'd0, rd_data[18]}, 32'd0);
    hw_speed = 4'd4;
    wr(32'h0000_0010);
    pulse_done();
    check("R9 speed reload", {28'd0, rd_data[13:10]}, 32'd4);
    wr(32'h00FE_0000);
    @(negedge clk); hw_connect = 1'b0;
    @(negedge clk);
    check("R10 hw disable", {31'd0, rd_data[1]}, 32'd0);
    check("R10 hw pec", {31'd0, rd_data[18]}, 32'd1);
    @(negedge clk); hw_connect = 1'b1;
    @(negedge clk);
    wr(32'h00FE_0000);

    // R12 config error and cold attach
    @(negedge clk); hw_cfg_err = 1'b1;
    @(negedge clk); hw_cfg_err = 1'b0;
    check("R12 cec", {31'd0, rd_data[23]}, 32'd1);
    @(negedge clk); hw_cold_attach = 1'b1;
    @(negedge clk); hw_cold_attach = 1'b0;
    check("R12 cas", {31'd0, rd_data[24]}, 32'd1);
    wr(32'h00FE_0000);

    // R5 warm reset
    wr(32'h8000_0000);
    check("R5 pr set", {31'd0, rd_data[4]}, 32'd1);
    check("R5 warm_active", {31'd0, warm_active}, 32'd1);
    check("R5 bit31 zero", {31'd0, rd_data[31]}, 32'd0);
    pulse_done();
    check("R5 wrc", {31'd0, rd_data[19]}, 32'd1);
    check("R5 prc", {31'd0, rd_data[21]}, 32'd1);
    check("R5 cas cleared", {31'd0, rd_data[24]}, 32'd0);
    check("R5 warm done", {31'd0, warm_active}, 32'd0);
    wr(32'h00FE_0000);

    // R11 read/write and reserved bits
    wr(32'h7E00_C204);
    check("R11 rw fields", rd_data & 32'hFE01_C204, 32'h0E00_C200);

    // R8 link change table
    foreach (VEC[i]) begin
      wr({15'd0, 1'b1, 7'd0, VEC[i][8:5], 5'd0});
      wr(32'h0040_0000);
      ls_report(VEC[i][4:1]);
      check($sformatf("R8 plc %0d->%0d", VEC[i][8:5], VEC[i][4:1]),
            {31'd0, rd_data[22]}, {31'd0, VEC[i][0]});
    end

    finish_run();
  end
endmodule